// File: doc/BRIEF.md
# Cache-Line Burst Read Engine

This block fetches one complete cache line from memory over a pipelined, Wishbone-style bus master. A requester pulses a one-cycle start strobe together with any byte address inside the wanted line. The engine rounds that address down to the start of the line. It then issues one read request per 32-bit word, in ascending order, and holds each request until the bus accepts it.

Every word that comes back is passed straight to the requester in the same cycle as its acknowledge. It arrives with a valid pulse, the read data and the byte address of that word, so a cache fill unit can write it into the correct slot. The acknowledge for the last word of the line also raises a last-word flag. The engine keeps bus ownership from the first request until that final acknowledge. It serves one line at a time, and a start pulse that arrives during a burst has no effect.

Top module: `line_burst_fetcher`

## Requirements
- R1: The first request of a line carries the start address with its low log2(LINE_BYTES) bits cleared. The strobe and the cycle signal both rise in the cycle after the start pulse.
- R2: While the strobe is high and stall is high, the request address and the cycle-type code do not change. Each request accepted with stall low advances the address by 4 bytes, and the strobe stays high until all LINE_BYTES/4 requests are accepted.
- R3: Every request except the one for the last word of the line carries cycle-type code 3'b010 (incrementing burst).
- R4: The request for the last word of the line carries cycle-type code 3'b111 (end of burst).
- R5: Once the last word's request has been accepted, the strobe stays low for the rest of the line.
- R6: The cycle signal stays high from the first request until the acknowledge of the last word, and is low in the cycle after that acknowledge.
- R7: An acknowledge during a burst produces, in the same cycle, a valid pulse with the bus read data and the address of the word being answered. Responses are numbered from word 0 upward in arrival order.
- R8: The last-word flag is high exactly once per line, together with the valid pulse for the acknowledge of word LINE_BYTES/4-1.
- R9: A start pulse while the cycle signal is high is ignored. Addresses, codes and ownership of the burst in progress are unchanged, and no second burst follows it.
- R10: After reset, cycle and strobe are low and the cycle-type output reads 3'b000. The cycle-type output also returns to 3'b000 when a line completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | One-cycle start pulse for a line fetch |
| fetch_addr | input | 32 | Any byte address within the wanted line |
| word_valid | output | 1 | A returned word is present this cycle |
| word_data | output | 32 | Returned word |
| word_addr | output | 32 | Byte address of the returned word |
| word_last | output | 1 | The returned word is the last of the line |
| bus_adr | output | 32 | Request byte address |
| bus_dat_i | input | 32 | Read data from the bus |
| bus_cti | output | 3 | Cycle-type code of the request |
| bus_cyc | output | 1 | Bus ownership |
| bus_stb | output | 1 | Request strobe |
| bus_stall | input | 1 | Slave cannot take a request this cycle |
| bus_ack | input | 1 | Read response strobe |

## Verification
A fault in the request counter shows up at the next accepted request. The bus address or the cycle-type code no longer matches the expected word index, and the end-of-burst code lands on the wrong word. A fault in the response counter shows up on the next acknowledge. The reported word address drifts, or the last-word flag comes early or late. A late flag also keeps the cycle signal high one acknowledge too long, which the bus model sees when the queue of pending requests runs dry. Random stall and acknowledge gaps separate the two counters, so a counter that moves on the wrong event breaks the very next word.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    typedef enum logic [2:0] {
        CTI_CLASSIC = 3'b000,
        CTI_INCR    = 3'b010,
        CTI_END     = 3'b111
    } cti_e;

    typedef struct packed {
        logic        valid;
        logic        last;
        logic [31:0] addr;
        logic [31:0] data;
    } word_resp_t;

    function automatic cti_e cti_for(input logic is_last);
        return is_last ? CTI_END : CTI_INCR;
    endfunction

endpackage

// File: rtl/lbf_req_issuer.sv
module lbf_req_issuer
    import lbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-OFS_W-1:0] line_tag,
    input  logic                    stall,
    input  logic                    line_done,
    output logic                    stb,
    output logic [ADDR_W-1:0]       adr,
    output logic [2:0]              cti
);
    localparam int IDX_W = OFS_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic             stb_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;
    logic [ADDR_W-1:0] adr_q;
    cti_e             cti_q;

    assign idx_nxt = idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            idx_q <= '0;
            adr_q <= '0;
            cti_q <= CTI_CLASSIC;
        end else if (start) begin
            stb_q <= 1'b1;
            idx_q <= '0;
            adr_q <= {line_tag, {OFS_W{1'b0}}};
            cti_q <= cti_for(LAST_IDX == '0);
        end else if (stb_q && !stall) begin
            if (idx_q == LAST_IDX) begin
                stb_q <= 1'b0;
            end else begin
                idx_q <= idx_nxt;
                adr_q <= {adr_q[ADDR_W-1:OFS_W], idx_nxt, 2'b00};
                cti_q <= cti_for(idx_nxt == LAST_IDX);
            end
        end else if (line_done) begin
            cti_q <= CTI_CLASSIC;
        end
    end

    assign stb = stb_q;
    assign adr = adr_q;
    assign cti = cti_q;

endmodule

// File: rtl/lbf_resp_tracker.sv
module lbf_resp_tracker
    import lbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-OFS_W-1:0] line_tag,
    input  logic                    active,
    input  logic                    ack,
    input  logic [31:0]             dat,
    output word_resp_t              resp
);
    localparam int IDX_W = OFS_W - 2;

    logic [ADDR_W-OFS_W-1:0] tag_q;
    logic [IDX_W-1:0]        ridx_q;
    logic                    hit;

    assign hit = active && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            ridx_q <= '0;
        end else if (start) begin
            tag_q  <= line_tag;
            ridx_q <= '0;
        end else if (hit) begin
            ridx_q <= ridx_q + 1'b1;
        end
    end

    always_comb begin
        resp       = '0;
        resp.valid = hit;
        resp.last  = hit && (ridx_q == {IDX_W{1'b1}});
        resp.addr  = 32'({tag_q, ridx_q, 2'b00});
        resp.data  = dat;
    end

endmodule

// File: rtl/line_burst_fetcher.sv
module line_burst_fetcher
    import lbf_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_req,
    input  logic [31:0] fetch_addr,
    output logic        word_valid,
    output logic [31:0] word_data,
    output logic [31:0] word_addr,
    output logic        word_last,
    output logic [31:0] bus_adr,
    input  logic [31:0] bus_dat_i,
    output logic [2:0]  bus_cti,
    output logic        bus_cyc,
    output logic        bus_stb,
    input  logic        bus_stall,
    input  logic        bus_ack
);
    localparam int ADDR_W = 32;
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

    logic                    cyc_q;
    logic                    start;
    logic [ADDR_W-1:0]       aligned;
    logic [ADDR_W-OFS_W-1:0] line_tag;
    word_resp_t              resp;

    assign start    = fetch_req && !cyc_q;
    assign aligned  = fetch_addr & ~OFS_MASK;
    assign line_tag = aligned[ADDR_W-1:OFS_W];

    always_ff @(posedge clk) begin
        if (rst)
            cyc_q <= 1'b0;
        else if (start)
            cyc_q <= 1'b1;
        else if (resp.last)
            cyc_q <= 1'b0;
    end

    lbf_req_issuer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .line_tag  (line_tag),
        .stall     (bus_stall),
        .line_done (resp.last),
        .stb       (bus_stb),
        .adr       (bus_adr),
        .cti       (bus_cti)
    );

    lbf_resp_tracker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .line_tag (line_tag),
        .active   (cyc_q),
        .ack      (bus_ack),
        .dat      (bus_dat_i),
        .resp     (resp)
    );

    assign bus_cyc    = cyc_q;
    assign word_valid = resp.valid;
    assign word_last  = resp.last;
    assign word_addr  = resp.addr;
    assign word_data  = resp.data;

endmodule

// File: rtl/line_burst_fetcher_chk.sv
module line_burst_fetcher_chk #(
    parameter int LINE_BYTES = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        fetch_req,
    input logic        word_valid,
    input logic        word_last,
    input logic [31:0] bus_adr,
    input logic [2:0]  bus_cti,
    input logic        bus_cyc,
    input logic        bus_stb,
    input logic        bus_stall
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!bus_cyc && !bus_stb && bus_cti == 3'b000)); // R10

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !bus_cyc) |=> (bus_cyc && bus_stb && bus_adr[OFS_W-1:0] == '0)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_stall) |=> (bus_stb && $stable(bus_adr) && $stable(bus_cti))); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_stall && bus_cti == 3'b010) |=> (bus_stb && bus_adr == $past(bus_adr) + 32'd4)); // R3

    AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_stall && bus_cti == 3'b111) |=> !bus_stb); // R5

    AST_STB_OWNED: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> bus_cyc); // R6

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        word_last |=> !bus_cyc); // R6

    AST_VALID_OWNED: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> bus_cyc); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && bus_cyc && bus_stb && bus_stall) |=> $stable(bus_adr)); // R9

endmodule

bind line_burst_fetcher line_burst_fetcher_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_req  (fetch_req),
    .word_valid (word_valid),
    .word_last  (word_last),
    .bus_adr    (bus_adr),
    .bus_cti    (bus_cti),
    .bus_cyc    (bus_cyc),
    .bus_stb    (bus_stb),
    .bus_stall  (bus_stall)
);

// File: tb/line_burst_fetcher_test.sv
`timescale 1ns/1ps
module line_burst_fetcher_test;
    localparam int LINE_BYTES = 32;
    localparam int WORDS      = LINE_BYTES / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        word_valid, word_last;
    logic [31:0] word_data, word_addr, bus_adr;
    logic [31:0] bus_dat_i = '0;
    logic [2:0]  bus_cti;
    logic        bus_cyc, bus_stb;
    logic        bus_stall = 1'b0;
    logic        bus_ack = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    line_burst_fetcher #(.LINE_BYTES(LINE_BYTES)) uut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .word_valid(word_valid), .word_data(word_data), .word_addr(word_addr),
        .word_last(word_last), .bus_adr(bus_adr), .bus_dat_i(bus_dat_i),
        .bus_cti(bus_cti), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_stall(bus_stall), .bus_ack(bus_ack)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [2:0] exp_cti(input int idx);
        return (idx == WORDS - 1) ? 3'b111 : 3'b010;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_line(input logic [31:0] a, input int stall_pct,
                            input int ack_pct, input bit inject);
        logic [31:0] base;
        logic [31:0] q [0:WORDS-1];
        int issued, acked, qt, cyc_n, qt0;
        bit doack;
        base   = a & ~32'(LINE_BYTES - 1);
        issued = 0; acked = 0; qt = 0; cyc_n = 0;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        while (acked < WORDS && !finished) begin
            @(negedge clk);
            cyc_n++;
            fetch_req  = inject && (cyc_n == 3);
            fetch_addr = a ^ 32'h0001_0040;
            chk(bus_cyc == 1'b1, "R6", "cyc during burst", 32'(bus_cyc), 32'd1);
            qt0 = qt;
            bus_stall = ($urandom_range(99) < stall_pct);
            if (issued < WORDS) begin
                chk(bus_stb == 1'b1, "R2", "strobe held until all issued", 32'(bus_stb), 32'd1);
                if (bus_stb) begin
                    if (issued == 0)
                        chk(bus_adr == base, "R1", "first address aligned", bus_adr, base);
                    else
                        chk(bus_adr == base + 32'(issued * 4), "R2 R9", "request address", bus_adr, base + 32'(issued * 4));
                    if (issued == WORDS - 1)
                        chk(bus_cti == exp_cti(issued), "R4", "end-of-burst code", 32'(bus_cti), 32'(exp_cti(issued)));
                    else
                        chk(bus_cti == exp_cti(issued), "R3", "incrementing code", 32'(bus_cti), 32'(exp_cti(issued)));
                    if (!bus_stall) begin
                        q[qt] = bus_adr;
                        qt++;
                        issued++;
                    end
                end
            end else begin
                chk(bus_stb == 1'b0, "R5", "no strobe after last request", 32'(bus_stb), 32'd0);
            end
            doack = (acked < qt0) && ($urandom_range(99) < ack_pct);
            bus_ack   = doack;
            bus_dat_i = doack ? mem_word(q[acked]) : 32'hDEAD_BEEF;
            #1;
            chk(word_valid == doack, "R7", "valid follows ack", 32'(word_valid), 32'(doack));
            if (doack) begin
                chk(word_addr == base + 32'(acked * 4), "R7", "word address", word_addr, base + 32'(acked * 4));
                chk(word_data == mem_word(q[acked]), "R7", "word data", word_data, mem_word(q[acked]));
                chk(word_last == (acked == WORDS - 1), "R8", "last flag", 32'(word_last), 32'(acked == WORDS - 1));
                acked++;
            end else begin
                chk(word_last == 1'b0, "R8", "last flag without ack", 32'(word_last), 32'd0);
            end
        end
        @(negedge clk);
        bus_ack = 1'b0; bus_stall = 1'b0; fetch_req = 1'b0;
        chk(bus_cyc == 1'b0, "R6", "cyc dropped after last ack", 32'(bus_cyc), 32'd0);
        chk(bus_stb == 1'b0, "R5", "strobe idle after line", 32'(bus_stb), 32'd0);
        chk(bus_cti == 3'b000, "R10", "code back to classic", 32'(bus_cti), 32'd0);
        if (inject) begin
            @(negedge clk);
            chk(bus_cyc == 1'b0, "R9", "no burst from ignored start", 32'(bus_cyc), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        chk(!bus_cyc && !bus_stb && bus_cti == 3'b000, "R10", "reset idle",
            {bus_cyc, bus_stb, 27'd0, bus_cti}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        run_line(32'h0000_1000, 0, 100, 0);
        run_line(32'h0000_2014, 0, 100, 0);
        run_line(32'h1234_567F, 80, 30, 0);
        run_line(32'hFFFF_FFFC, 50, 50, 0);
        run_line(32'h0000_0040, 40, 60, 1);
        run_line(32'h8000_0008, 0, 20, 1);
        for (int i = 0; i < 25; i++)
            run_line($urandom, $urandom_range(70), 20 + $urandom_range(80), ($urandom_range(3) == 0));
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule